// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

This block is a memory-mapped watchdog. A down-counter runs while the timer is enabled. It steps either on every clock or only on cycles where an external slow tick input is high, which stands for a fixed 5 MHz time base. When a step finds the counter at zero, the timeout fires. The counter then reloads itself from the load register and keeps running. A sticky status bit records the timeout. Up to three outputs (system reset, system interrupt and an external signal) are raised as a pulse whose length software programs.

Software keeps the system alive by writing a 16-bit key to the restart register, which reloads the counter. Any other value written there does nothing. The status bit is cleared only through a separate write-only clear register. All registers are reached through a simple register bus: byte address, write strobe, write data and combinational read data.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the load register reads 0x03EF1480, the counter reads the same value, the pulse-length register reads 0xFF, and control and status read 0.
- R2: Byte offsets: counter 0x00 (read-only), load 0x04, restart 0x08 (write-only), control 0x0C, status 0x10 (read-only), clear 0x14 (write-only), pulse length 0x18. Write-only offsets read 0, unused bits read 0, and writes to read-only offsets change nothing.
- R3: Control bit 0 enables counting and bit 4 selects the step source: 0 steps every clock, 1 steps only on clocks where the tick input is 1. While bit 0 is 0 the counter holds its value.
- R4: A step taken with the counter at 0 is a timeout. It reloads the counter from the load register, so with load value L the timeout happens on the (L+1)-th step after a reload.
- R5: A write to offset 0x08 whose bits 15:0 equal 0x5AB9 reloads the counter from the load register on that clock edge, whether or not the timer is enabled, and upper bits are ignored. Any other value leaves the counter unchanged.
- R6: Status bit 0 is set by a timeout and stays set until a write to 0x14 with bit 0 = 1. A write with bit 0 = 0 has no effect, and a timeout in the same cycle as a clear wins.
- R7: After a timeout edge, the active outputs are high for exactly N+1 clock cycles, where N is the pulse-length value, starting in the cycle after that edge. A new timeout restarts the pulse.
- R8: Each output is gated by its own control bit: bit 1 for system reset, bit 2 for system interrupt, bit 3 for the external signal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (5) | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i |
| tick_i | input | 1 | Slow time-base tick, one clock wide |
| sys_rst_o | output | 1 | System reset pulse |
| irq_o | output | 1 | System interrupt pulse |
| ext_o | output | 1 | External signal pulse |

## Verification
The bench sweeps small load and pulse-length values and counts cycles from enable to the first output edge. A design off by one in the zero test would fire after L or L+2 steps instead of L+1. Pulse widths are measured for every length below the load value, which catches a stretcher that runs for N or N+2 cycles. The tick-driven source is checked by counting only ticked clocks, so a design that ignores the tick or the select bit fires far too early. The bench also tries a key with one bit wrong and a key with nonzero upper bits: the first must leave the counter untouched, the second must reload it. Writes of zero to the clear register and writes to read-only offsets must not change what reads back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_LOAD    = 8'h04;
    localparam logic [7:0] OFF_RESTART = 8'h08;
    localparam logic [7:0] OFF_CTRL    = 8'h0C;
    localparam logic [7:0] OFF_STATUS  = 8'h10;
    localparam logic [7:0] OFF_CLEAR   = 8'h14;
    localparam logic [7:0] OFF_PLEN    = 8'h18;

    localparam logic [15:0] RESTART_KEY = 16'h5AB9;

    // Control register layout, bit 0 at the right.
    typedef struct packed {
        logic src_tick;   // bit 4: 1 = step on tick input
        logic ext_en;     // bit 3
        logic irq_en;     // bit 2
        logic rst_en;     // bit 1
        logic run;        // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 5,
    parameter int          CNT_W    = 32,
    parameter int          LEN_W    = 8,
    parameter logic [CNT_W-1:0] LOAD_RST = CNT_W'(32'h03EF1480),
    parameter logic [LEN_W-1:0] LEN_RST  = LEN_W'(8'hFF)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              expire_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              restart_o
);

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [LEN_W-1:0] len;
        ctrl_t            ctrl;
        logic             status;
    } regs_t;

    regs_t r_d, r_q;

    logic sel_count, sel_load, sel_restart, sel_ctrl;
    logic sel_status, sel_clear, sel_plen;
    logic clear_hit;

    always_comb begin
        sel_count   = (addr_i == ADDR_W'(OFF_COUNT));
        sel_load    = (addr_i == ADDR_W'(OFF_LOAD));
        sel_restart = (addr_i == ADDR_W'(OFF_RESTART));
        sel_ctrl    = (addr_i == ADDR_W'(OFF_CTRL));
        sel_status  = (addr_i == ADDR_W'(OFF_STATUS));
        sel_clear   = (addr_i == ADDR_W'(OFF_CLEAR));
        sel_plen    = (addr_i == ADDR_W'(OFF_PLEN));
    end

    always_comb begin
        r_d       = r_q;
        restart_o = wr_en_i && sel_restart && (wdata_i[15:0] == RESTART_KEY);
        clear_hit = wr_en_i && sel_clear && wdata_i[0];

        if (wr_en_i && sel_load) r_d.load = CNT_W'(wdata_i);
        if (wr_en_i && sel_ctrl) r_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        if (wr_en_i && sel_plen) r_d.len  = wdata_i[LEN_W-1:0];

        // A timeout in the same cycle as a clear keeps the bit set.
        if (expire_i)       r_d.status = 1'b1;
        else if (clear_hit) r_d.status = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.load   <= LOAD_RST;
            r_q.len    <= LEN_RST;
            r_q.ctrl   <= '0;
            r_q.status <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_count)  rdata_o = DATA_W'(count_i);
        if (sel_load)   rdata_o = DATA_W'(r_q.load);
        if (sel_ctrl)   rdata_o = DATA_W'(r_q.ctrl);
        if (sel_status) rdata_o = DATA_W'(r_q.status);
        if (sel_plen)   rdata_o = DATA_W'(r_q.len);
    end

    assign ctrl_o = r_q.ctrl;
    assign load_o = r_q.load;
    assign len_o  = r_q.len;

    // R6: status only leaves 1 through a clear write.
    assert_status_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.status && !(wr_en_i && sel_clear && wdata_i[0])) |=> r_q.status);

    // R6: status only rises on a timeout.
    assert_status_set_only_by_expire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!r_q.status && !expire_i) |=> !r_q.status);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int               CNT_W    = 32,
    parameter logic [CNT_W-1:0] LOAD_RST = CNT_W'(32'h03EF1480)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             src_tick_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t c_d, c_q;
    logic step;

    always_comb begin
        c_d      = c_q;
        step     = run_i && (src_tick_i ? tick_i : 1'b1);
        expire_o = 1'b0;
        if (restart_i) begin
            c_d.count = load_i;
        end else if (step) begin
            if (c_q.count == '0) begin
                c_d.count = load_i;
                expire_o  = 1'b1;
            end else begin
                c_d.count = c_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q.count <= LOAD_RST;
        else         c_q       <= c_d;
    end

    assign count_o = c_q.count;

    // R3: a stopped timer holds its value unless restarted.
    assert_hold_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> $stable(c_q.count));

    // R5: a key hit reloads from the load register.
    assert_key_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (c_q.count == $past(load_i)));

    // R4: a timeout leaves the load value in the counter.
    assert_reload_on_expire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> (c_q.count == $past(load_i)));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN_W = 8,
    localparam int PW   = LEN_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             expire_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             active_o
);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (expire_i)             p_d.left = PW'(len_i) + 1'b1;
        else if (p_q.left != '0)  p_d.left = p_q.left - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q.left <= '0;
        else         p_q      <= p_d;
    end

    assign active_o = (p_q.left != '0);

    // R7: a timeout arms the stretcher for length + 1 cycles.
    assert_pulse_arm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> (p_q.left == PW'($past(len_i)) + 1'b1));

    // R7: without a new timeout the remaining time falls by one each cycle.
    assert_pulse_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!expire_i && p_q.left != '0) |=> (p_q.left == $past(p_q.left) - 1'b1));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tick_i,
    output logic              sys_rst_o,
    output logic              irq_o,
    output logic              ext_o
);

    localparam logic [CNT_W-1:0] LOAD_RST = CNT_W'(32'h03EF1480);
    localparam logic [LEN_W-1:0] LEN_RST  = LEN_W'(8'hFF);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] count;
    logic [LEN_W-1:0] len;
    logic             restart;
    logic             expire;
    logic             active;

    wdog_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
        .LOAD_RST(LOAD_RST), .LEN_RST(LEN_RST)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .count_i(count), .expire_i(expire), .rdata_o(rdata_o),
        .ctrl_o(ctrl), .load_o(load), .len_o(len), .restart_o(restart)
    );

    wdog_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .src_tick_i(ctrl.src_tick),
        .tick_i(tick_i), .restart_i(restart), .load_i(load), .count_o(count),
        .expire_o(expire)
    );

    wdog_pulse #(.LEN_W(LEN_W)) u_pulse (
        .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .len_i(len),
        .active_o(active)
    );

    assign sys_rst_o = active && ctrl.rst_en;
    assign irq_o     = active && ctrl.irq_en;
    assign ext_o     = active && ctrl.ext_en;

    // R7: an output can only rise one cycle after a timeout edge.
    assert_irq_rise_after_expire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active && !expire) |=> !active);

endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
    import wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        sys_rst, irq, ext;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    wdog_keyed u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .tick_i(tick), .sys_rst_o(sys_rst), .irq_o(irq), .ext_o(ext)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Ends 1 ns after the edge that takes the write.
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        addr = a[4:0]; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a[4:0]; wr = 1'b0;
        #1 d = rdata;
    endtask

    task automatic quiesce();
        wr_reg(OFF_CTRL, 32'h0);
        repeat (20) @(posedge clk);
        #1;
        wr_reg(OFF_CLEAR, 32'h1);
    endtask

    // Bus-clock sweep case: time to first output, all three outputs, and width.
    task automatic bus_case(input int L, input int N);
        int n, w;
        logic [31:0] v;
        quiesce();
        wr_reg(OFF_LOAD, L);
        wr_reg(OFF_PLEN, N);
        wr_reg(OFF_RESTART, 32'h5AB9);
        wr_reg(OFF_CTRL, 32'h0F);
        n = 0;
        while (n < 200) begin
            @(posedge clk); n++; #1;
            if (irq) break;
        end
        chk($sformatf("R4 steps to timeout L=%0d", L), n, L + 1);
        chk("R8 reset out with irq", {31'b0, sys_rst}, 1);
        chk("R8 ext out with irq", {31'b0, ext}, 1);
        rd_reg(OFF_STATUS, v);
        chk("R6 status after timeout", v, 1);
        w = 0;
        while (irq && w < 300) begin
            w++; @(posedge clk); #1;
        end
        chk($sformatf("R7 pulse width L=%0d N=%0d", L, N), w, N + 1);
    endtask

    // Tick-source case: only ticked clocks count as steps.
    task automatic tick_case(input int L);
        int n, steps;
        logic last;
        quiesce();
        wr_reg(OFF_LOAD, L);
        wr_reg(OFF_PLEN, 0);
        wr_reg(OFF_RESTART, 32'h5AB9);
        wr_reg(OFF_CTRL, 32'h1F);
        n = 0; steps = 0; last = 1'b0;
        while (n < 300) begin
            tick = (n % 3 == 1);
            last = tick;
            @(posedge clk);
            if (last) steps++;
            n++; #1;
            if (irq) break;
        end
        tick = 1'b0;
        chk($sformatf("R3 ticked steps to timeout L=%0d", L), steps, L + 1);
        chk("R3 timeout lands on a ticked clock", {31'b0, last}, 1);
        chk($sformatf("R3 clocks to timeout L=%0d", L), n, 3 * L + 2);
    endtask

    task automatic gate_case(input logic [31:0] c);
        quiesce();
        wr_reg(OFF_LOAD, 2);
        wr_reg(OFF_PLEN, 1);
        wr_reg(OFF_RESTART, 32'h5AB9);
        wr_reg(OFF_CTRL, c);
        repeat (3) @(posedge clk);
        #1;
        chk($sformatf("R8 reset gate ctrl=%0h", c), {31'b0, sys_rst}, {31'b0, c[1]});
        chk($sformatf("R8 irq gate ctrl=%0h", c), {31'b0, irq}, {31'b0, c[2]});
        chk($sformatf("R8 ext gate ctrl=%0h", c), {31'b0, ext}, {31'b0, c[3]});
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            vectors++; fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values, R2 write-only reads
        rd_reg(OFF_COUNT, v);   chk("R1 counter reset", v, 32'h03EF1480);
        rd_reg(OFF_LOAD, v);    chk("R1 load reset", v, 32'h03EF1480);
        rd_reg(OFF_CTRL, v);    chk("R1 ctrl reset", v, 0);
        rd_reg(OFF_STATUS, v);  chk("R1 status reset", v, 0);
        rd_reg(OFF_PLEN, v);    chk("R1 length reset", v, 32'hFF);
        rd_reg(OFF_RESTART, v); chk("R2 restart reads 0", v, 0);
        rd_reg(OFF_CLEAR, v);   chk("R2 clear reads 0", v, 0);
        chk("R1 outputs low", {29'b0, sys_rst, irq, ext}, 0);

        // R2 unused bits and read-only offsets
        wr_reg(OFF_PLEN, 32'hFFFF_FF5A);
        rd_reg(OFF_PLEN, v);    chk("R2 length width", v, 32'h5A);
        wr_reg(OFF_COUNT, 32'h1234);
        rd_reg(OFF_COUNT, v);   chk("R2 counter not writable", v, 32'h03EF1480);
        wr_reg(OFF_STATUS, 32'h1);
        rd_reg(OFF_STATUS, v);  chk("R2 status not writable", v, 0);
        wr_reg(OFF_CTRL, 32'hFFFF_FFE0);
        rd_reg(OFF_CTRL, v);    chk("R2 ctrl unused bits", v, 0);

        // R3 counting on the bus clock and holding when stopped
        wr_reg(OFF_LOAD, 1000);
        wr_reg(OFF_RESTART, 32'h5AB9);
        rd_reg(OFF_COUNT, v);   chk("R5 key reload while stopped", v, 1000);
        wr_reg(OFF_CTRL, 32'h01);
        rd_reg(OFF_COUNT, v);
        repeat (5) @(posedge clk);
        rd_reg(OFF_COUNT, v2);  chk("R3 five clocks five steps", v - v2, 5);
        wr_reg(OFF_CTRL, 32'h00);
        rd_reg(OFF_COUNT, v);
        repeat (7) @(posedge clk);
        rd_reg(OFF_COUNT, v2);  chk("R3 stopped counter holds", v2, v);

        // R5 key handling
        wr_reg(OFF_LOAD, 77);
        wr_reg(OFF_RESTART, 32'h0000_5AB8);
        rd_reg(OFF_COUNT, v2);  chk("R5 wrong key ignored", v2, v);
        wr_reg(OFF_RESTART, 32'h0000_DAB9);
        rd_reg(OFF_COUNT, v2);  chk("R5 high-bit key ignored", v2, v);
        wr_reg(OFF_RESTART, 32'hABCD_5AB9);
        rd_reg(OFF_COUNT, v2);  chk("R5 key with upper bits reloads", v2, 77);

        // R4 and R7 sweep on the bus clock
        for (int L = 1; L <= 6; L++)
            for (int N = 0; N < L; N++)
                bus_case(L, N);

        // R3 tick source
        for (int L = 0; L <= 4; L++)
            tick_case(L);

        // R8 per-output gating
        gate_case(32'h03);
        gate_case(32'h05);
        gate_case(32'h09);

        // R6 sticky status and clear semantics
        wr_reg(OFF_CTRL, 32'h0);
        rd_reg(OFF_STATUS, v);  chk("R6 status still set", v, 1);
        wr_reg(OFF_CLEAR, 32'hFFFF_FFFE);
        rd_reg(OFF_STATUS, v);  chk("R6 clear with bit0=0 no effect", v, 1);
        repeat (4) @(posedge clk);
        rd_reg(OFF_STATUS, v);  chk("R6 status holds over time", v, 1);
        wr_reg(OFF_CLEAR, 32'h1);
        rd_reg(OFF_STATUS, v);  chk("R6 clear with bit0=1", v, 0);

        done = 1'b1;
        report();
    end

endmodule